// File: doc/BRIEF.md
# Memory-Access and Writeback Stage

This block is the last stage of a three-stage in-order pipeline. Each cycle it may take one packet from the decode/execute stage. A packet carries a status word, an instruction word and two data words. The stage then does one of three things. For arithmetic results, it writes the value to the register file. For loads and stores, it performs the data-memory transaction and waits for the reply, which may take several cycles. For control transfers whose outcome was already decided upstream, it redirects fetch to a new PC and asks fetch and decode to discard their contents.

Only one data-memory transaction is in flight at a time. While it is pending, the stage holds off the decode/execute stage through a ready signal, and a packet presented during that time stays where it is until the ready signal returns. All outputs come from registers: a register write, a memory request or a redirect appears in the cycle after the clock edge that causes it.

Top module: `mawb_unit`

## Requirements
- R1: After reset, `pkt_ready_o` is 1 and `mem_req_o`, `rf_we_o` and `flush_o` are 0.
- R2: A packet is accepted on a clock edge where `pkt_ready_o` is 1 and status bit 0 (valid) is 1. The operation is taken from instruction bits [31:29]: 0 none, 1 arithmetic, 2 load, 3 store, 4 conditional branch, 5 jump, and 6 and 7 have no effect. The destination register is taken from bits [4:0]. An accepted arithmetic packet with a nonzero destination gives `rf_we_o`=1 in the next cycle, with `rf_addr_o` set to the destination and `rf_wdata_o` set to data1, for exactly one cycle.
- R3: An accepted load gives a one-cycle `mem_req_o` in the next cycle, with `mem_we_o`=0 and `mem_addr_o`=data1. In the cycle after the reply is sampled (`mem_rsp_i`=1), `rf_we_o`=1 writes `mem_rdata_i` to the load's destination.
- R4: An accepted store gives a one-cycle `mem_req_o` in the next cycle, with `mem_we_o`=1, `mem_addr_o`=data1 and `mem_wdata_o`=data2. Its reply is an acknowledgement only and causes no register write.
- R5: From the edge that accepts a load or store until the edge that samples its reply, `pkt_ready_o` is 0 and no further `mem_req_o` is raised. A reply that arrives in the same cycle as the request, or while nothing is pending, is ignored.
- R6: An accepted jump, or an accepted conditional branch with status bit 1 (taken) set to 1, raises `flush_o` for one cycle in the next cycle, with `redir_pc_o` equal to instruction bits [23:8].
- R7: An accepted conditional branch with status bit 1 equal to 0 raises no `flush_o`.
- R8: A packet with status bit 0 equal to 0 causes no memory request, no register write and no flush.
- R9: A register write to register 0 is never issued, whether it would come from an arithmetic packet or from a load. A load to register 0 still performs its memory read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_status_i | input | STATUS_W | Status word; bit 0 valid, bit 1 branch taken |
| pkt_instr_i | input | INSTR_W | Instruction word: operation, destination, branch target |
| pkt_data1_i | input | DATA_W | Result value or memory address |
| pkt_data2_i | input | DATA_W | Store data |
| pkt_ready_o | output | 1 | Stage can accept a packet this cycle |
| mem_req_o | output | 1 | Data-memory request pulse |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | ADDR_W | Request address |
| mem_wdata_o | output | DATA_W | Request write data |
| mem_rsp_i | input | 1 | Memory reply / acknowledgement |
| mem_rdata_i | input | DATA_W | Read data with the reply |
| rf_we_o | output | 1 | Register write enable |
| rf_addr_o | output | REG_AW | Register write index |
| rf_wdata_o | output | DATA_W | Register write value |
| flush_o | output | 1 | Discard fetch and decode contents, load new PC |
| redir_pc_o | output | PC_W | New PC for fetch |

## Verification
The bench checks loads and stores with reply latencies drawn from 2 to 8 cycles. During the wait it checks that ready stays low, that no second request appears and that no register write leaks out early. A design that dropped ready too late would let a second request overlap the first. A design that wrote on the request cycle would write stale read data. A packet held at the input during a pending load must be taken only after the load's write. If a design accepted it early, the arithmetic write would appear before the load's write, or would be lost. The bench also covers a taken branch against a not-taken one, jumps, invalid packets that carry a load operation, and writes aimed at register 0. Each of these shows up at the ports as a spurious flush, a missing flush, a stray request or a write to register 0.

// File: rtl/mawb_pkg.sv
package mawb_pkg;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_ARITH  = 3'd1,
    OP_LOAD   = 3'd2,
    OP_STORE  = 3'd3,
    OP_BRANCH = 3'd4,
    OP_JUMP   = 3'd5
  } op_e;

  typedef enum logic {
    MS_IDLE = 1'b0,
    MS_WAIT = 1'b1
  } mstate_e;

  localparam int VALID_BIT = 0;
  localparam int TAKEN_BIT = 1;
  localparam int TGT_LSB   = 8;

  typedef struct packed {
    logic wr;
    logic ld;
    logic st;
    logic redir;
  } cls_t;

endpackage

// File: rtl/mawb_decode.sv
module mawb_decode
  import mawb_pkg::*;
#(
  parameter int STATUS_W = 8,
  parameter int INSTR_W  = 32,
  parameter int REG_AW   = 5,
  parameter int PC_W     = 16
) (
  input  logic [STATUS_W-1:0] status_i,
  input  logic [INSTR_W-1:0]  instr_i,
  output cls_t                cls_o,
  output logic [REG_AW-1:0]   dest_o,
  output logic [PC_W-1:0]     target_o
);

  localparam int OP_LSB = INSTR_W - 3;

  logic [2:0] op;
  logic       vld;
  logic       taken;

  always_comb begin
    op       = instr_i[INSTR_W-1:OP_LSB];
    vld      = status_i[VALID_BIT];
    taken    = status_i[TAKEN_BIT];
    dest_o   = instr_i[REG_AW-1:0];
    target_o = instr_i[TGT_LSB+PC_W-1:TGT_LSB];
    cls_o.wr    = vld && (op == OP_ARITH) && (dest_o != '0);
    cls_o.ld    = vld && (op == OP_LOAD);
    cls_o.st    = vld && (op == OP_STORE);
    cls_o.redir = vld && ((op == OP_JUMP) || ((op == OP_BRANCH) && taken));
  end

endmodule

// File: rtl/mawb_mem_ctrl.sv
module mawb_mem_ctrl
  import mawb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              is_store_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [REG_AW-1:0] dest_i,
  input  logic              rsp_i,
  output logic              idle_o,
  output logic              req_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              ld_done_o,
  output logic [REG_AW-1:0] ld_dest_o
);

  mstate_e           state_q, state_d;
  logic              req_q, req_d;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              pend_ld_q;
  logic [REG_AW-1:0] pend_dest_q;
  logic              rsp_ok;

  // a reply counts only in the wait state and never in the request cycle
  assign rsp_ok = (state_q == MS_WAIT) && !req_q && rsp_i;

  always_comb begin
    state_d = state_q;
    req_d   = 1'b0;
    case (state_q)
      MS_IDLE: if (start_i) begin
        state_d = MS_WAIT;
        req_d   = 1'b1;
      end
      MS_WAIT: if (rsp_ok) state_d = MS_IDLE;
      default: state_d = MS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MS_IDLE;
      req_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      req_q   <= req_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q        <= 1'b0;
      addr_q      <= '0;
      wdata_q     <= '0;
      pend_ld_q   <= 1'b0;
      pend_dest_q <= '0;
    end else if (req_d) begin
      we_q        <= is_store_i;
      addr_q      <= addr_i;
      wdata_q     <= wdata_i;
      pend_ld_q   <= !is_store_i;
      pend_dest_q <= dest_i;
    end
  end

  assign idle_o    = (state_q == MS_IDLE);
  assign req_o     = req_q;
  assign we_o      = we_q;
  assign addr_o    = addr_q;
  assign wdata_o   = wdata_q;
  assign ld_done_o = rsp_ok && pend_ld_q && (pend_dest_q != '0);
  assign ld_dest_o = pend_dest_q;

endmodule

// File: rtl/mawb_wb_port.sv
module mawb_wb_port #(
  parameter int DATA_W = 32,
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alu_wr_i,
  input  logic [REG_AW-1:0] alu_dest_i,
  input  logic [DATA_W-1:0] alu_data_i,
  input  logic              ld_wr_i,
  input  logic [REG_AW-1:0] ld_dest_i,
  input  logic [DATA_W-1:0] ld_data_i,
  output logic              we_o,
  output logic [REG_AW-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o
);

  logic              we_d;
  logic [REG_AW-1:0] addr_d;
  logic [DATA_W-1:0] data_d;

  // the two sources are exclusive: one needs the idle state, the other the wait state
  always_comb begin
    we_d   = alu_wr_i || ld_wr_i;
    addr_d = ld_wr_i ? ld_dest_i : alu_dest_i;
    data_d = ld_wr_i ? ld_data_i : alu_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_o <= 1'b0;
    else        we_o <= we_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_o  <= '0;
      wdata_o <= '0;
    end else if (we_d) begin
      addr_o  <= addr_d;
      wdata_o <= data_d;
    end
  end

endmodule

// File: rtl/mawb_redirect.sv
module mawb_redirect #(
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire_i,
  input  logic [PC_W-1:0] target_i,
  output logic            flush_o,
  output logic [PC_W-1:0] pc_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flush_o <= 1'b0;
    else        flush_o <= fire_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pc_o <= '0;
    else if (fire_i) pc_o <= target_i;
  end

endmodule

// File: rtl/mawb_unit.sv
module mawb_unit
  import mawb_pkg::*;
#(
  parameter int STATUS_W = 8,
  parameter int INSTR_W  = 32,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 32,
  parameter int REG_AW   = 5,
  parameter int PC_W     = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [STATUS_W-1:0] pkt_status_i,
  input  logic [INSTR_W-1:0]  pkt_instr_i,
  input  logic [DATA_W-1:0]   pkt_data1_i,
  input  logic [DATA_W-1:0]   pkt_data2_i,
  output logic                pkt_ready_o,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [DATA_W-1:0]   mem_wdata_o,
  input  logic                mem_rsp_i,
  input  logic [DATA_W-1:0]   mem_rdata_i,
  output logic                rf_we_o,
  output logic [REG_AW-1:0]   rf_addr_o,
  output logic [DATA_W-1:0]   rf_wdata_o,
  output logic                flush_o,
  output logic [PC_W-1:0]     redir_pc_o
);

  cls_t              cls;
  logic [REG_AW-1:0] dest;
  logic [PC_W-1:0]   target;
  logic              idle;
  logic              take;
  logic              ld_done;
  logic [REG_AW-1:0] ld_dest;

  mawb_decode #(
    .STATUS_W(STATUS_W), .INSTR_W(INSTR_W), .REG_AW(REG_AW), .PC_W(PC_W)
  ) u_dec (
    .status_i(pkt_status_i), .instr_i(pkt_instr_i),
    .cls_o(cls), .dest_o(dest), .target_o(target)
  );

  // classification already folds in the valid bit
  assign take        = idle;
  assign pkt_ready_o = idle;

  mawb_mem_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_AW(REG_AW)
  ) u_mem (
    .clk(clk), .rst_n(rst_n),
    .start_i(take && (cls.ld || cls.st)), .is_store_i(cls.st),
    .addr_i(pkt_data1_i[ADDR_W-1:0]), .wdata_i(pkt_data2_i), .dest_i(dest),
    .rsp_i(mem_rsp_i), .idle_o(idle),
    .req_o(mem_req_o), .we_o(mem_we_o), .addr_o(mem_addr_o), .wdata_o(mem_wdata_o),
    .ld_done_o(ld_done), .ld_dest_o(ld_dest)
  );

  mawb_wb_port #(
    .DATA_W(DATA_W), .REG_AW(REG_AW)
  ) u_wb (
    .clk(clk), .rst_n(rst_n),
    .alu_wr_i(take && cls.wr), .alu_dest_i(dest), .alu_data_i(pkt_data1_i),
    .ld_wr_i(ld_done), .ld_dest_i(ld_dest), .ld_data_i(mem_rdata_i),
    .we_o(rf_we_o), .addr_o(rf_addr_o), .wdata_o(rf_wdata_o)
  );

  mawb_redirect #(
    .PC_W(PC_W)
  ) u_redir (
    .clk(clk), .rst_n(rst_n),
    .fire_i(take && cls.redir), .target_i(target),
    .flush_o(flush_o), .pc_o(redir_pc_o)
  );

endmodule

// File: rtl/mawb_chk.sv
module mawb_chk #(
  parameter int STATUS_W = 8,
  parameter int INSTR_W  = 32,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 32,
  parameter int REG_AW   = 5,
  parameter int PC_W     = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic [STATUS_W-1:0] pkt_status_i,
  input logic [INSTR_W-1:0]  pkt_instr_i,
  input logic [DATA_W-1:0]   pkt_data1_i,
  input logic                pkt_ready_o,
  input logic                mem_req_o,
  input logic                mem_we_o,
  input logic                mem_rsp_i,
  input logic [DATA_W-1:0]   mem_rdata_i,
  input logic                rf_we_o,
  input logic [REG_AW-1:0]   rf_addr_o,
  input logic [DATA_W-1:0]   rf_wdata_o,
  input logic                flush_o,
  input logic [PC_W-1:0]     redir_pc_o
);

  localparam int OP_LSB = INSTR_W - 3;

  logic              outst_q;
  logic              st_q;
  logic [REG_AW-1:0] dst_q;
  logic              acc;
  logic [2:0]        op;
  logic [REG_AW-1:0] dst;

  assign acc = pkt_ready_o && pkt_status_i[0];
  assign op  = pkt_instr_i[INSTR_W-1:OP_LSB];
  assign dst = pkt_instr_i[REG_AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outst_q <= 1'b0;
      st_q    <= 1'b0;
      dst_q   <= '0;
    end else begin
      if (acc) dst_q <= dst;
      if (mem_req_o) begin
        outst_q <= 1'b1;
        st_q    <= mem_we_o;
      end else if (outst_q && mem_rsp_i) begin
        outst_q <= 1'b0;
      end
    end
  end

  p_arith_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op == 3'd1 && dst != '0) |=> (rf_we_o && rf_wdata_o == $past(pkt_data1_i)));

  p_load_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (outst_q && !st_q && mem_rsp_i && dst_q != '0) |=> (rf_we_o && rf_wdata_o == $past(mem_rdata_i)));

  p_store_nowrite_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (outst_q && st_q && mem_rsp_i) |=> !rf_we_o);

  p_single_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    outst_q |-> !mem_req_o);

  p_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (outst_q || mem_req_o) |-> !pkt_ready_o);

  p_jump_redirect_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op == 3'd5) |=> (flush_o && redir_pc_o == $past(pkt_instr_i[8+PC_W-1:8])));

  p_not_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op == 3'd4 && !pkt_status_i[1]) |=> !flush_o);

  p_invalid_inert_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_ready_o && !pkt_status_i[0]) |=> (!mem_req_o && !rf_we_o && !flush_o));

  p_no_reg0_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we_o |-> (rf_addr_o != '0));

endmodule

bind mawb_unit mawb_chk #(
  .STATUS_W(STATUS_W), .INSTR_W(INSTR_W), .DATA_W(DATA_W),
  .ADDR_W(ADDR_W), .REG_AW(REG_AW), .PC_W(PC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .pkt_status_i(pkt_status_i), .pkt_instr_i(pkt_instr_i), .pkt_data1_i(pkt_data1_i),
  .pkt_ready_o(pkt_ready_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
  .mem_rsp_i(mem_rsp_i), .mem_rdata_i(mem_rdata_i),
  .rf_we_o(rf_we_o), .rf_addr_o(rf_addr_o), .rf_wdata_o(rf_wdata_o),
  .flush_o(flush_o), .redir_pc_o(redir_pc_o)
);

// File: tb/mawb_unit_tb.sv
module mawb_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  st_i;
  logic [31:0] ins_i, d1_i, d2_i;
  logic        ready;
  logic        mreq, mwe;
  logic [31:0] maddr, mwdata;
  logic        rsp_i;
  logic [31:0] rdata_i;
  logic        rfwe;
  logic [4:0]  rfaddr;
  logic [31:0] rfdata;
  logic        flush;
  logic [15:0] rpc;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  mawb_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .pkt_status_i(st_i), .pkt_instr_i(ins_i), .pkt_data1_i(d1_i), .pkt_data2_i(d2_i),
    .pkt_ready_o(ready),
    .mem_req_o(mreq), .mem_we_o(mwe), .mem_addr_o(maddr), .mem_wdata_o(mwdata),
    .mem_rsp_i(rsp_i), .mem_rdata_i(rdata_i),
    .rf_we_o(rfwe), .rf_addr_o(rfaddr), .rf_wdata_o(rfdata),
    .flush_o(flush), .redir_pc_o(rpc)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [2:0] op, input logic [4:0] dest, input logic [15:0] tgt);
    mk = {op, 5'd0, tgt, 3'd0, dest};
  endfunction

  task automatic send(input logic [7:0] st, input logic [31:0] ins, input logic [31:0] d1, input logic [31:0] d2);
    @(negedge clk);
    st_i = st; ins_i = ins; d1_i = d1; d2_i = d2;
    @(negedge clk);
    st_i = 8'h00; ins_i = $urandom; d1_i = $urandom; d2_i = $urandom;
  endtask

  task automatic mem_op(input bit is_st, input logic [4:0] dest, input logic [31:0] addr,
                        input logic [31:0] wd, input logic [31:0] rd, input int lat);
    send(8'h01, mk(is_st ? 3'd3 : 3'd2, dest, 16'h0), addr, wd);
    if (is_st) begin
      chk("R4", "store req", {62'd0, mreq, mwe}, 64'd3);
      chk("R4", "store addr", maddr, addr);
      chk("R4", "store wdata", mwdata, wd);
    end else begin
      chk("R3", "load req", {62'd0, mreq, mwe}, 64'd2);
      chk("R3", "load addr", maddr, addr);
    end
    chk("R5", "ready in req cycle", ready, 0);
    for (int k = 1; k < lat; k++) begin
      @(negedge clk);
      chk("R5", "no second req", mreq, 0);
      chk("R5", "ready while waiting", ready, 0);
      chk("R3", "no early write", rfwe, 0);
    end
    rsp_i = 1'b1; rdata_i = rd;
    @(negedge clk);
    rsp_i = 1'b0; rdata_i = $urandom;
    chk("R5", "ready after reply", ready, 1);
    if (!is_st && dest != 5'd0) begin
      chk("R3", "load write", {31'd0, rfwe, 27'd0, rfaddr}, {31'd0, 1'b1, 27'd0, dest});
      chk("R3", "load data", rfdata, rd);
    end else begin
      chk(is_st ? "R4" : "R9", "no write", rfwe, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h1DEA5);
    rst_n = 1'b0; st_i = 0; ins_i = 0; d1_i = 0; d2_i = 0; rsp_i = 0; rdata_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "ready", ready, 1);
    chk("R1", "req/we/flush", {61'd0, mreq, rfwe, flush}, 0);

    // R2 arithmetic writes, random destinations and data
    for (int i = 0; i < 20; i++) begin
      logic [4:0]  dst;
      logic [31:0] v;
      dst = 5'($urandom_range(1, 31));
      v = $urandom;
      send(8'h01, mk(3'd1, dst, 16'($urandom)), v, $urandom);
      chk("R2", "arith we/addr", {31'd0, rfwe, 27'd0, rfaddr}, {31'd0, 1'b1, 27'd0, dst});
      chk("R2", "arith data", rfdata, v);
      chk("R2", "no side effects", {62'd0, mreq, flush}, 0);
    end
    @(negedge clk);
    chk("R2", "write lasts one cycle", rfwe, 0);

    // R9 arithmetic to register 0
    send(8'h01, mk(3'd1, 5'd0, 16'h0), 32'hDEAD_BEEF, 0);
    chk("R9", "reg0 arith", rfwe, 0);

    // R3 loads, R4 stores with random latency
    for (int i = 0; i < 12; i++)
      mem_op(1'b0, 5'($urandom_range(1, 31)), $urandom, $urandom, $urandom, $urandom_range(2, 8));
    for (int i = 0; i < 8; i++)
      mem_op(1'b1, 5'($urandom_range(0, 31)), $urandom, $urandom, $urandom, $urandom_range(2, 8));
    // R9 load to register 0 still reads memory
    mem_op(1'b0, 5'd0, 32'h40, 0, 32'h1234, 3);

    // R5 packet held at the input during a pending load
    send(8'h01, mk(3'd2, 5'd7, 16'h0), 32'h100, 0);
    chk("R5", "req for held case", mreq, 1);
    st_i = 8'h01; ins_i = mk(3'd1, 5'd9, 16'h0); d1_i = 32'hA5A5_0009;
    @(negedge clk);
    rsp_i = 1'b1; rdata_i = 32'h0BAD_F00D;   // stray reply in req cycle was avoided; this one counts
    chk("R5", "no arith write while held", rfwe, 0);
    @(negedge clk);
    rsp_i = 1'b0;
    chk("R5", "load write first", {32'd0, 27'd0, rfaddr}, 64'd7);
    chk("R5", "load data first", rfdata, 32'h0BAD_F00D);
    @(negedge clk);
    st_i = 8'h00;
    chk("R5", "held arith then written", {31'd0, rfwe, 27'd0, rfaddr}, {31'd0, 1'b1, 27'd0, 5'd9});
    chk("R5", "held arith data", rfdata, 32'hA5A5_0009);

    // R5 reply in the request cycle is ignored
    send(8'h01, mk(3'd3, 5'd0, 16'h0), 32'h80, 32'h55);
    rsp_i = 1'b1;
    @(negedge clk);
    rsp_i = 1'b0;
    chk("R5", "early reply ignored", ready, 0);
    rsp_i = 1'b1;
    @(negedge clk);
    rsp_i = 1'b0;
    chk("R5", "real ack releases", ready, 1);
    // R5 stray reply while idle
    rsp_i = 1'b1; rdata_i = 32'h77;
    @(negedge clk);
    rsp_i = 1'b0;
    @(negedge clk);
    chk("R5", "stray reply inert", {62'd0, rfwe, ready}, 64'd1);

    // R6 jumps and taken branches
    for (int i = 0; i < 6; i++) begin
      logic [15:0] t;
      t = 16'($urandom);
      if (i % 2 == 0) send(8'h01, mk(3'd5, 5'd0, t), 0, 0);
      else            send(8'h03, mk(3'd4, 5'd0, t), 0, 0);
      chk("R6", "flush", flush, 1);
      chk("R6", "new pc", rpc, t);
    end
    @(negedge clk);
    chk("R6", "flush one cycle", flush, 0);

    // R7 branch not taken
    send(8'h01, mk(3'd4, 5'd0, 16'h1111), 0, 0);
    chk("R7", "no flush", flush, 0);

    // R8 invalid packets carrying effects
    send(8'h02, mk(3'd2, 5'd3, 16'h0), 32'h10, 0);
    chk("R8", "invalid load inert", {61'd0, mreq, rfwe, flush}, 0);
    chk("R8", "still ready", ready, 1);
    send(8'h02, mk(3'd5, 5'd0, 16'h2222), 0, 0);
    chk("R8", "invalid jump inert", flush, 0);
    send(8'h00, mk(3'd1, 5'd4, 16'h0), 32'h99, 0);
    chk("R8", "invalid arith inert", rfwe, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule